// File: doc/BRIEF.md
# System Status Flags Register

This block is a 32-bit read-only status word for a small system-on-chip. The word combines three kinds of bits. Some are live pin levels, a few of them inverted. Some are sticky event flags, set by edges or by reset causes and cleared by bus writes. One field holds the display identification nibble, captured from the four display data lines when the display enable turns on. Other internal blocks supply their status as synchronous inputs: the serial port flags, the real-time-clock divider count, the display enable, the standby indication and the power-fail reset strobe.

Every asynchronous pin passes through a synchroniser before it is read or edge-detected. For a few cycles after any reset, edge detection is held off. Software reads the word at its own address and gets it one cycle later. A write to the clear address drops the four reset-cause flags. A write to the halt or standby entry address drops the wake flag. A write to the word's own address does nothing.

There are two resets. `por` is the power-on reset: it sets the cold-start flag and clears every other flag. `rst` is the ordinary system reset: it clears the wake flag but keeps the four reset-cause flags.

Top module: `sys_status_flags`

## Requirements
- R1: Bit 0 reads as the inverse of the synchronised media-change pin. Bit 1 reads as the inverse of the active-low external-power pin. Bit 2 reads as the wakeup pin level. All three are unlatched.
- R2: Bits 8, 9 and 10 read as the live clear-to-send, data-set-ready and carrier-detect pins. Bit 11 is the transmit-busy input, bits 21:16 the 6-bit divider count, bit 22 receive-empty, bit 23 transmit-full and bits 31:30 the VERSION parameter. Bits 29:24 read 0.
- R3: Bit 3 (wake) sets on a rising edge of the synchronised wakeup pin while `standby_i` is 1. A rising edge while `standby_i` is 0 leaves it clear.
- R4: Bit 3 clears on a write to the halt address (2) or the standby address (3), and on `rst`.
- R5: Bits 7:4 take the synchronised display data lines on the cycle `lcd_en_i` goes from 0 to 1. They hold that value while the enable stays high, even if the lines change, and take a new value at the next rising edge of the enable.
- R6: Bit 12 sets on a low-to-high transition of the battery-change pin. A high-to-low transition does not set it.
- R7: Bit 13 sets when the active-low user reset pin is low. Bit 14 sets when `pwrfail_rst_i` is 1 for a cycle.
- R8: A write to the clear address (1) clears bits 15:12. Writes to other addresses leave them alone. If a set event and a clearing write fall in the same cycle, the flag ends up set.
- R9: `por` sets bit 15, clears bits 14:12 and bit 3, and keeps them that way while asserted. `rst` leaves bits 15:12 unchanged.
- R10: A read with `bus_rd_i` at address 0 returns the word in `rdata_o` on the next cycle. Any other cycle leaves `rdata_o` at 0. A write to address 0 changes nothing.
- R11: After either reset, edge detection stays off for SYNC_STAGES+1 cycles. A wakeup pin that is already high at reset release does not set bit 3, even in standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | System reset, synchronous, active high |
| por | input | 1 | Power-on reset, synchronous, active high |
| bus_addr_i | input | ADDR_W | Word address of the access |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data |
| media_chg_i | input | 1 | Media-change pin, asynchronous |
| ext_pwr_n_i | input | 1 | External-power pin, active low, asynchronous |
| wakeup_i | input | 1 | Wakeup pin, asynchronous |
| cts_i | input | 1 | Clear-to-send pin, asynchronous |
| dsr_i | input | 1 | Data-set-ready pin, asynchronous |
| dcd_i | input | 1 | Carrier-detect pin, asynchronous |
| batt_chg_n_i | input | 1 | Battery-change pin, asynchronous |
| usr_rst_n_i | input | 1 | User reset button, active low, asynchronous |
| lcd_data_i | input | 4 | Display data lines, asynchronous |
| lcd_en_i | input | 1 | Display enable control bit |
| standby_i | input | 1 | System is in standby |
| pwrfail_rst_i | input | 1 | Strobe: last reset came from power fail |
| uart_tx_busy_i | input | 1 | Serial transmitter busy |
| uart_rx_empty_i | input | 1 | Serial receive queue empty |
| uart_tx_full_i | input | 1 | Serial transmit queue full |
| rtc_div_i | input | 6 | Real-time-clock divider count |

## Verification
The bench holds the wakeup pin high and standby asserted across a system reset. A design with no arming window would see a false edge from the reset value of the synchroniser and raise the wake flag. It fires a power-fail strobe in the same cycle as a clear write. A design with clear-over-set priority would lose that event and read bit 14 as 0. It changes the display lines while the enable is held high, where a design that tracks the lines would show the new nibble. It also pulses `rst` with the reset-cause flags set, where a design that clears them on any reset would erase the cold-start bit.

// File: rtl/sysflg_pkg.sv
package sysflg_pkg;

  localparam int WORD_W = 32;

  // field positions inside the status word
  localparam int B_MEDIA_N   = 0;
  localparam int B_EXTPWR    = 1;
  localparam int B_WAKE_LVL  = 2;
  localparam int B_WAKE_FLG  = 3;
  localparam int B_DISP_LO   = 4;
  localparam int B_CTS       = 8;
  localparam int B_DSR       = 9;
  localparam int B_DCD       = 10;
  localparam int B_TX_BUSY   = 11;
  localparam int B_NEWBAT    = 12;
  localparam int B_USRRST    = 13;
  localparam int B_PWRFAIL   = 14;
  localparam int B_COLD      = 15;
  localparam int B_RTC_LO    = 16;
  localparam int B_RX_EMPTY  = 22;
  localparam int B_TX_FULL   = 23;
  localparam int B_VER_LO    = 30;

  // asynchronous pin lanes into the synchroniser
  localparam int P_MEDIA  = 0;
  localparam int P_EXTN   = 1;
  localparam int P_WAKE   = 2;
  localparam int P_CTS    = 3;
  localparam int P_DSR    = 4;
  localparam int P_DCD    = 5;
  localparam int P_BATTN  = 6;
  localparam int P_USRN   = 7;
  localparam int P_LCD_LO = 8;
  localparam int PIN_W    = 12;

  // sticky flag lanes
  localparam int F_WAKE    = 0;
  localparam int F_NEWBAT  = 1;
  localparam int F_USRRST  = 2;
  localparam int F_PWRFAIL = 3;
  localparam int F_COLD    = 4;
  localparam int FLAG_N    = 5;

endpackage

// File: rtl/sysflg_sync.sv
module sysflg_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] chain_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= RST_VAL;
    end else begin
      chain_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/sysflg_edge.sv
module sysflg_edge #(
  parameter int W          = 1,
  parameter int ARM_CYCLES = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);

  localparam int CW = $clog2(ARM_CYCLES + 1);

  logic [W-1:0]  prev_q;
  logic [CW-1:0] arm_cnt_q;
  logic          armed;

  assign armed = (arm_cnt_q == CW'(ARM_CYCLES));

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q    <= '0;
      arm_cnt_q <= '0;
    end else begin
      prev_q <= lvl_i;
      if (!armed) arm_cnt_q <= arm_cnt_q + 1'b1;
    end
  end

  assign rise_o = lvl_i & ~prev_q & {W{armed}};

  // R11: once armed, the window never re-closes without a reset
  a_r11_stays_armed: assert property (@(posedge clk) disable iff (rst)
    armed |=> armed);

endmodule

// File: rtl/sysflg_capture.sv
module sysflg_capture #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] nib_o
);

  logic en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      nib_o <= '0;
    end else begin
      en_q <= en_i;
      if (en_i && !en_q) nib_o <= data_i;
    end
  end

  // R5: while the enable stays high, the captured nibble is frozen
  a_r5_hold_while_on: assert property (@(posedge clk) disable iff (rst)
    (en_q && en_i) |=> $stable(nib_o));

endmodule

// File: rtl/sysflg_sticky.sv
module sysflg_sticky #(
  parameter int           N    = 5,
  parameter logic [N-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         por,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);

  genvar k;
  generate
    for (k = 0; k < N; k++) begin : g_flag
      always_ff @(posedge clk) begin
        if (por)           flag_o[k] <= INIT[k];
        else if (set_i[k]) flag_o[k] <= 1'b1;
        else if (clr_i[k]) flag_o[k] <= 1'b0;
      end

      // R8: an event is never lost to a simultaneous clear
      a_r8_set_wins: assert property (@(posedge clk) disable iff (por)
        set_i[k] |=> flag_o[k]);

      // R8: a clear with no competing event drops the flag
      a_r8_clear_drops: assert property (@(posedge clk) disable iff (por)
        (clr_i[k] && !set_i[k]) |=> !flag_o[k]);

      // a flag with neither event nor clear keeps its value
      a_r8_hold: assert property (@(posedge clk) disable iff (por)
        (!clr_i[k] && !set_i[k] && !$isunknown(flag_o[k])) |=> $stable(flag_o[k]));
    end
  endgenerate

  // R9: power-on reset loads the initial pattern
  a_r9_por_init: assert property (@(posedge clk)
    por |=> (flag_o == INIT));

endmodule

// File: rtl/sys_status_flags.sv
module sys_status_flags
  import sysflg_pkg::*;
#(
  parameter int         ADDR_W      = 4,
  parameter int         SYNC_STAGES = 2,
  parameter int         A_FLAGS     = 0,
  parameter int         A_CLEAR     = 1,
  parameter int         A_HALT      = 2,
  parameter int         A_STDBY     = 3,
  parameter logic [1:0] VERSION     = 2'b01
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  output logic [31:0]       rdata_o,
  input  logic              media_chg_i,
  input  logic              ext_pwr_n_i,
  input  logic              wakeup_i,
  input  logic              cts_i,
  input  logic              dsr_i,
  input  logic              dcd_i,
  input  logic              batt_chg_n_i,
  input  logic              usr_rst_n_i,
  input  logic [3:0]        lcd_data_i,
  input  logic              lcd_en_i,
  input  logic              standby_i,
  input  logic              pwrfail_rst_i,
  input  logic              uart_tx_busy_i,
  input  logic              uart_rx_empty_i,
  input  logic              uart_tx_full_i,
  input  logic [5:0]        rtc_div_i
);

  localparam int                ARM_CYCLES = SYNC_STAGES + 1;
  localparam logic [PIN_W-1:0]  PIN_RST    = PIN_W'((1 << P_BATTN) | (1 << P_USRN));
  localparam logic [FLAG_N-1:0] FLAG_INIT  = FLAG_N'(1 << F_COLD);

  logic any_rst;
  assign any_rst = rst | por;

  // ---------------- pin synchronisation ----------------
  logic [PIN_W-1:0] pins_raw, pins_s;

  always_comb begin
    pins_raw                       = '0;
    pins_raw[P_MEDIA]              = media_chg_i;
    pins_raw[P_EXTN]               = ext_pwr_n_i;
    pins_raw[P_WAKE]               = wakeup_i;
    pins_raw[P_CTS]                = cts_i;
    pins_raw[P_DSR]                = dsr_i;
    pins_raw[P_DCD]                = dcd_i;
    pins_raw[P_BATTN]              = batt_chg_n_i;
    pins_raw[P_USRN]               = usr_rst_n_i;
    pins_raw[P_LCD_LO +: 4]        = lcd_data_i;
  end

  sysflg_sync #(
    .W       (PIN_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (PIN_RST)
  ) u_sync (
    .clk (clk),
    .rst (any_rst),
    .d_i (pins_raw),
    .q_o (pins_s)
  );

  // ---------------- edge detection ----------------
  logic [1:0] edge_lvl, edge_rise;
  assign edge_lvl = {pins_s[P_BATTN], pins_s[P_WAKE]};

  sysflg_edge #(
    .W          (2),
    .ARM_CYCLES (ARM_CYCLES)
  ) u_edge (
    .clk    (clk),
    .rst    (any_rst),
    .lvl_i  (edge_lvl),
    .rise_o (edge_rise)
  );

  logic wake_rise, batt_rise;
  assign wake_rise = edge_rise[0];
  assign batt_rise = edge_rise[1];

  // ---------------- bus decode ----------------
  logic wr_clear, wr_mode, rd_hit;
  assign wr_clear = bus_wr_i && (bus_addr_i == ADDR_W'(A_CLEAR));
  assign wr_mode  = bus_wr_i && ((bus_addr_i == ADDR_W'(A_HALT)) ||
                                 (bus_addr_i == ADDR_W'(A_STDBY)));
  assign rd_hit   = bus_rd_i && (bus_addr_i == ADDR_W'(A_FLAGS));

  // ---------------- sticky flags ----------------
  logic [FLAG_N-1:0] flag_set, flag_clr, flags;

  always_comb begin
    flag_set            = '0;
    flag_set[F_WAKE]    = wake_rise & standby_i;
    flag_set[F_NEWBAT]  = batt_rise;
    flag_set[F_USRRST]  = ~pins_s[P_USRN];
    flag_set[F_PWRFAIL] = pwrfail_rst_i;
    flag_clr            = '0;
    flag_clr[F_WAKE]    = rst | wr_mode;
    flag_clr[F_NEWBAT]  = wr_clear;
    flag_clr[F_USRRST]  = wr_clear;
    flag_clr[F_PWRFAIL] = wr_clear;
    flag_clr[F_COLD]    = wr_clear;
  end

  sysflg_sticky #(
    .N    (FLAG_N),
    .INIT (FLAG_INIT)
  ) u_sticky (
    .clk    (clk),
    .por    (por),
    .set_i  (flag_set),
    .clr_i  (flag_clr),
    .flag_o (flags)
  );

  // ---------------- display ID capture ----------------
  logic [3:0] disp_id;

  sysflg_capture #(
    .W (4)
  ) u_cap (
    .clk    (clk),
    .rst    (any_rst),
    .en_i   (lcd_en_i),
    .data_i (pins_s[P_LCD_LO +: 4]),
    .nib_o  (disp_id)
  );

  // ---------------- word assembly and read ----------------
  logic [WORD_W-1:0] word;

  always_comb begin
    word                   = '0;
    word[B_MEDIA_N]        = ~pins_s[P_MEDIA];
    word[B_EXTPWR]         = ~pins_s[P_EXTN];
    word[B_WAKE_LVL]       = pins_s[P_WAKE];
    word[B_WAKE_FLG]       = flags[F_WAKE];
    word[B_DISP_LO +: 4]   = disp_id;
    word[B_CTS]            = pins_s[P_CTS];
    word[B_DSR]            = pins_s[P_DSR];
    word[B_DCD]            = pins_s[P_DCD];
    word[B_TX_BUSY]        = uart_tx_busy_i;
    word[B_NEWBAT]         = flags[F_NEWBAT];
    word[B_USRRST]         = flags[F_USRRST];
    word[B_PWRFAIL]        = flags[F_PWRFAIL];
    word[B_COLD]           = flags[F_COLD];
    word[B_RTC_LO +: 6]    = rtc_div_i;
    word[B_RX_EMPTY]       = uart_rx_empty_i;
    word[B_TX_FULL]        = uart_tx_full_i;
    word[B_VER_LO +: 2]    = VERSION;
  end

  always_ff @(posedge clk) begin
    if (any_rst)     rdata_o <= '0;
    else if (rd_hit) rdata_o <= word;
    else             rdata_o <= '0;
  end

  // R10: outside a read of the status address the data bus rests at zero
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (any_rst)
    !rd_hit |=> (rdata_o == '0));

  // R3: a wake edge during standby is visible in the flag next cycle
  a_r3_wake_sets: assert property (@(posedge clk) disable iff (any_rst)
    (wake_rise && standby_i) |=> flags[F_WAKE]);

  // R9: power-on reset leaves the cold-start flag raised
  a_r9_cold_after_por: assert property (@(posedge clk)
    por |=> flags[F_COLD]);

endmodule

// File: tb/tb_sys_status_flags.sv
module tb_sys_status_flags;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 4;
  localparam logic [ADDR_W-1:0] AD_FLAGS = 4'd0;
  localparam logic [ADDR_W-1:0] AD_CLEAR = 4'd1;
  localparam logic [ADDR_W-1:0] AD_HALT  = 4'd2;
  localparam logic [ADDR_W-1:0] AD_STDBY = 4'd3;
  localparam logic [31:0] LIVE_MASK = 32'hFFFF_0F07;
  localparam int NV = 6;

  // stim lanes: 0 media,1 ext_pwr_n,2 wakeup,3 cts,4 dsr,5 dcd,6 tx busy,7 rx empty,8 tx full,14:9 divider
  localparam logic [15:0] STIM [NV] = '{16'h0002, 16'h54AD, 16'h7F52, 16'h7FFF, 16'h0000, 16'h2A03};
  localparam logic [31:0] EXPV [NV] = '{32'h4000_0001, 32'h406A_0506, 32'h40BF_0A01,
                                        32'h40FF_0F04, 32'h4000_0003, 32'h4015_0000};

  logic clk = 1'b0;
  logic rst = 1'b0, por = 1'b1;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] rdata;
  logic media = 1'b1, ext_n = 1'b1, wake = 1'b0, cts = 1'b0, dsr = 1'b0, dcd = 1'b0;
  logic batt_n = 1'b1, usr_n = 1'b1;
  logic [3:0] lcd_data = 4'h0;
  logic lcd_en = 1'b0, standby = 1'b0, pwrfail = 1'b0;
  logic tx_busy = 1'b0, rx_empty = 1'b0, tx_full = 1'b0;
  logic [5:0] rtc = 6'h0;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  logic [31:0] rv, rv_prev;

  always #(CLK_PERIOD/2) clk = ~clk;

  sys_status_flags dut (
    .clk(clk), .rst(rst), .por(por),
    .bus_addr_i(bus_addr), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd), .rdata_o(rdata),
    .media_chg_i(media), .ext_pwr_n_i(ext_n), .wakeup_i(wake),
    .cts_i(cts), .dsr_i(dsr), .dcd_i(dcd),
    .batt_chg_n_i(batt_n), .usr_rst_n_i(usr_n),
    .lcd_data_i(lcd_data), .lcd_en_i(lcd_en), .standby_i(standby),
    .pwrfail_rst_i(pwrfail),
    .uart_tx_busy_i(tx_busy), .uart_rx_empty_i(rx_empty), .uart_tx_full_i(tx_full),
    .rtc_div_i(rtc)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic do_read(input logic [ADDR_W-1:0] a, output logic [31:0] v);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; bus_addr = '0;
    v = rdata;
  endtask

  task automatic do_write(input logic [ADDR_W-1:0] a);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a;
    @(negedge clk); bus_wr = 1'b0; bus_addr = '0;
  endtask

  task automatic pulse_rst();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
  endtask

  task automatic pulse_pwrfail();
    @(negedge clk); pwrfail = 1'b1;
    @(negedge clk); pwrfail = 1'b0;
  endtask

  task automatic apply(input logic [15:0] s);
    media = s[0]; ext_n = s[1]; wake = s[2]; cts = s[3]; dsr = s[4]; dcd = s[5];
    tx_busy = s[6]; rx_empty = s[7]; tx_full = s[8]; rtc = s[14:9];
  endtask

  task automatic wake_edge();
    wake = 1'b0; settle();
    wake = 1'b1; settle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    por = 1'b0;
    // reset state: no read yet
    check("R10 idle after por", rdata, 32'h0);
    settle();
    do_read(AD_FLAGS, rv);
    check("R9 reset word", rv, 32'h4000_8000);

    // table of live-bit patterns (R1, R2)
    for (int i = 0; i < NV; i++) begin
      apply(STIM[i]);
      settle();
      do_read(AD_FLAGS, rv);
      check("R1 R2 live bits", rv & LIVE_MASK, EXPV[i]);
    end
    apply(16'h0003);
    settle();

    // R10: wrong address reads zero, write to own address ignored
    do_read(AD_HALT, rv);
    check("R10 other address", rv, 32'h0);
    do_read(AD_FLAGS, rv_prev);
    do_write(AD_FLAGS);
    do_read(AD_FLAGS, rv);
    check("R10 write to word ignored", rv, rv_prev);

    // R3 / R4 wake flag
    standby = 1'b1;
    wake_edge();
    do_read(AD_FLAGS, rv);
    check("R3 wake set in standby", 32'(rv[3]), 32'd1);
    do_write(AD_HALT);
    do_read(AD_FLAGS, rv);
    check("R4 halt write clears wake", 32'(rv[3]), 32'd0);
    wake_edge();
    do_write(AD_STDBY);
    do_read(AD_FLAGS, rv);
    check("R4 standby write clears wake", 32'(rv[3]), 32'd0);
    wake_edge();
    do_read(AD_FLAGS, rv);
    check("R3 wake set again", 32'(rv[3]), 32'd1);
    // wakeup pin stays high and standby stays on across the reset
    pulse_rst();
    settle();
    do_read(AD_FLAGS, rv);
    check("R4 R11 rst clears wake, no false edge", 32'(rv[3]), 32'd0);
    check("R9 rst keeps cold flag", 32'(rv[15]), 32'd1);
    standby = 1'b0;
    wake_edge();
    do_read(AD_FLAGS, rv);
    check("R3 no wake outside standby", 32'(rv[3]), 32'd0);
    wake = 1'b0;

    // R5 display nibble
    lcd_data = 4'hA; settle();
    @(negedge clk); lcd_en = 1'b1;
    settle();
    do_read(AD_FLAGS, rv);
    check("R5 capture on enable", 32'(rv[7:4]), 32'hA);
    lcd_data = 4'h5; settle();
    do_read(AD_FLAGS, rv);
    check("R5 hold while enabled", 32'(rv[7:4]), 32'hA);
    @(negedge clk); lcd_en = 1'b0;
    settle();
    @(negedge clk); lcd_en = 1'b1;
    settle();
    do_read(AD_FLAGS, rv);
    check("R5 recapture", 32'(rv[7:4]), 32'h5);

    // R6 new battery
    batt_n = 1'b0; settle();
    do_read(AD_FLAGS, rv);
    check("R6 falling edge no set", 32'(rv[12]), 32'd0);
    batt_n = 1'b1; settle();
    do_read(AD_FLAGS, rv);
    check("R6 rising edge sets", 32'(rv[12]), 32'd1);

    // R7 user reset and power fail
    usr_n = 1'b0; settle();
    usr_n = 1'b1; settle();
    do_read(AD_FLAGS, rv);
    check("R7 user reset flag", 32'(rv[13]), 32'd1);
    pulse_pwrfail(); settle();
    do_read(AD_FLAGS, rv);
    check("R7 power-fail flag", 32'(rv[14]), 32'd1);
    check("R8 all four set before clear", 32'(rv[15:12]), 32'hF);

    // R8 clear and priority
    do_write(AD_HALT);
    do_read(AD_FLAGS, rv);
    check("R8 other write keeps flags", 32'(rv[15:12]), 32'hF);
    do_write(AD_CLEAR);
    do_read(AD_FLAGS, rv);
    check("R8 clear write", 32'(rv[15:12]), 32'h0);
    usr_n = 1'b0; settle();
    usr_n = 1'b1; settle();
    @(negedge clk); bus_wr = 1'b1; bus_addr = AD_CLEAR; pwrfail = 1'b1;
    @(negedge clk); bus_wr = 1'b0; bus_addr = '0; pwrfail = 1'b0;
    do_read(AD_FLAGS, rv);
    check("R8 set wins over clear", 32'(rv[15:12]), 32'h4);

    // R9 power-on reset
    standby = 1'b1;
    wake_edge();
    do_read(AD_FLAGS, rv);
    check("R3 wake set before por", 32'(rv[3]), 32'd1);
    @(negedge clk); por = 1'b1;
    repeat (2) @(negedge clk); por = 1'b0;
    settle();
    do_read(AD_FLAGS, rv);
    check("R9 por flags", 32'(rv[15:12]), 32'h8);
    check("R9 R11 por clears wake", 32'(rv[3]), 32'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule